// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which power mode a small microcontroller is in and drives the clock, I/O and peripheral-reset controls that follow from it. The CPU asks for a low-power mode with a single request line. A select bit picks light sleep, where only the CPU clock stops, or deep standby, where the whole clock generator stops, the pins float and chosen peripherals are reset. A qualified interrupt brings the part back. A second bit picks whether it returns at full speed (active) or on the slow clock (subactive).

Leaving standby is not immediate. The qualifying interrupt loads a settling counter from a programmable count. Clocks stay off and the pins stay floating until that count has run out. This gives the oscillator time to become stable before anything uses it. The reset pin overrides every mode. The peripheral clock divider select is passed through unchanged, so the peripherals run at the chosen rate in every mode that clocks them.

Top module: `pmc_power_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows mode 0 with `cpu_clk_en`, `per_clk_en`, `io_hiz` and `periph_rst` all 0. The first edge with `rst_n` high moves the mode to active (1).
- R2: `mode` encodes 0 = reset, 1 = active, 2 = subactive, 3 = sleep, 4 = standby (this includes the settling interval). In active and subactive both clock enables are 1 and `io_hiz` is 0.
- R3: From active or subactive, `sleep_req` = 1 with `standby_sel` = 0 gives mode 3 on the next cycle. In sleep `cpu_clk_en` is 0 and `per_clk_en` is 1.
- R4: `per_div_sel` equals `clk_div_sel` in every cycle and every mode.
- R5: A wake is qualified only when some bit has both `irq_req` and `irq_en` set and `int_mask` is 0. Without a qualified wake, sleep and standby are held, whatever `sleep_req` does.
- R6: A qualified wake in sleep leaves sleep on the next edge. The new mode is active when `low_speed_sel` is 0 and subactive when it is 1.
- R7: From active or subactive, `sleep_req` = 1 with `standby_sel` = 1 gives mode 4 on the next cycle, with both clock enables 0 and `io_hiz` 1.
- R8: `periph_rst` equals the `periph_rst_mask` value sampled at the standby entry edge, during the first standby cycle only. It is 0 in every other cycle.
- R9: A qualified wake in standby loads `settle_cycles` = S. The mode stays 4, with clocks off and `io_hiz` 1, for S+1 further cycles. It then becomes active or subactive, chosen by `low_speed_sel` at that exit edge.
- R10: `rst_n` low overrides sleep, standby, settling, pending wakes and sleep requests. The next cycle shows mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset pin, sampled synchronously |
| sleep_req | input | 1 | CPU request to enter a low-power mode |
| standby_sel | input | 1 | 1 selects standby, 0 selects sleep |
| low_speed_sel | input | 1 | Wake target: 0 active, 1 subactive |
| clk_div_sel | input | DIV_W | Peripheral clock divider select |
| irq_req | input | NUM_IRQ | Interrupt request lines |
| irq_en | input | NUM_IRQ | Interrupt enable bits |
| int_mask | input | 1 | CPU interrupt mask bit, 1 blocks wake |
| periph_rst_mask | input | NUM_PERIPH | Per-peripheral select for reset on standby entry |
| settle_cycles | input | SETTLE_W | Oscillator settling count for standby exit |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| per_div_sel | output | DIV_W | Divider select forwarded to the clock generator |
| io_hiz | output | 1 | Forces I/O pins to high impedance |
| periph_rst | output | NUM_PERIPH | One-cycle reset strobes to peripherals |
| mode | output | 3 | Current mode code |

## Verification
A low-power request can arrive in the same cycle as an interrupt that already qualifies as a wake. The controller must first take the low-power mode and leave it on the following edge; it must not skip the mode or stay in it. The bench forces this case directly with `sleep_req`, an enabled request and a clear mask all driven together. Random stimulus also produces it often, and a reset pulse sometimes lands on top of a wake. A cycle-level reference model in the bench judges every cycle: it expects one sleep cycle and then the wake target, while reset overrides both.

// File: rtl/pmc_pkg.sv
// Shared types for the power mode controller.
// Assumes: mode codes are seen outside the block and must stay fixed.
package pmc_pkg;

    // Externally visible mode codes.
    typedef enum logic [2:0] {
        MODE_RESET   = 3'd0,
        MODE_ACTIVE  = 3'd1,
        MODE_SUBACT  = 3'd2,
        MODE_SLEEP   = 3'd3,
        MODE_STANDBY = 3'd4
    } pmc_mode_e;

    // Internal sequencer states; settling reports as standby.
    typedef enum logic [2:0] {
        ST_RESET,
        ST_ACTIVE,
        ST_SUBACT,
        ST_SLEEP,
        ST_STANDBY,
        ST_SETTLE
    } pmc_state_e;

endpackage

// File: rtl/pmc_wake_qual.sv
// Wake qualifier: reports a wake when some request line is enabled
// and the CPU mask bit is clear. Purely combinational.
// Assumes: request and enable lines are already synchronous to clk.
module pmc_wake_qual #(
    parameter int NUM_IRQ = 8
) (
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               int_mask,
    output logic               wake
);

    logic [NUM_IRQ-1:0] live;

    // Per-line qualification of request by enable.
    genvar g;
    generate
        for (g = 0; g < NUM_IRQ; g++) begin : g_line
            assign live[g] = irq_req[g] & irq_en[g];
        end
    endgenerate

    // Any live line wakes unless the CPU mask blocks it.
    always_comb wake = (|live) & ~int_mask;

endmodule

// File: rtl/pmc_settle_cnt.sv
// Oscillator settling counter: loads a count and counts down to zero.
// done is high whenever the count is zero.
// Assumes: synchronous active-low reset clears the count.
module pmc_settle_cnt #(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SETTLE_W-1:0] load_val,
    output logic                done
);

    localparam logic [SETTLE_W-1:0] CNT_ONE = SETTLE_W'(1);

    logic [SETTLE_W-1:0] cnt_q;

    // Load on request, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - CNT_ONE;
    end

    // Expiry flag.
    always_comb done = (cnt_q == '0);

    // R9: a running count drops by exactly one per cycle.
    p_count_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

    // R9: a load is taken exactly.
    p_count_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/pmc_rst_strobe.sv
// Peripheral reset strobe: on fire, drives the mask for one cycle.
// Assumes: fire is never high in two cycles in a row.
module pmc_rst_strobe #(
    parameter int NUM_PERIPH = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fire,
    input  logic [NUM_PERIPH-1:0] mask,
    output logic [NUM_PERIPH-1:0] strobe
);

    genvar g;
    generate
        for (g = 0; g < NUM_PERIPH; g++) begin : g_per
            // One register per peripheral strobe.
            always_ff @(posedge clk) begin
                if (!rst_n) strobe[g] <= 1'b0;
                else        strobe[g] <= fire & mask[g];
            end
        end
    endgenerate

endmodule

// File: rtl/pmc_power_ctrl.sv
// Power mode controller top. Sequences reset, active, subactive, sleep,
// standby and standby settling, and derives clock, I/O and reset controls.
// Assumes: all inputs synchronous to clk; rst_n is the reset pin, sampled
// synchronously; the clock generator honours the enables within a cycle.
module pmc_power_ctrl #(
    parameter int NUM_IRQ    = 8,
    parameter int NUM_PERIPH = 6,
    parameter int SETTLE_W   = 8,
    parameter int DIV_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sleep_req,
    input  logic                  standby_sel,
    input  logic                  low_speed_sel,
    input  logic [DIV_W-1:0]      clk_div_sel,
    input  logic [NUM_IRQ-1:0]    irq_req,
    input  logic [NUM_IRQ-1:0]    irq_en,
    input  logic                  int_mask,
    input  logic [NUM_PERIPH-1:0] periph_rst_mask,
    input  logic [SETTLE_W-1:0]   settle_cycles,
    output logic                  cpu_clk_en,
    output logic                  per_clk_en,
    output logic [DIV_W-1:0]      per_div_sel,
    output logic                  io_hiz,
    output logic [NUM_PERIPH-1:0] periph_rst,
    output logic [2:0]            mode
);
    import pmc_pkg::*;

    pmc_state_e state_q, state_d;
    pmc_state_e wake_dest;
    logic       wake, settle_done, running, enter_stby, settle_load;

    pmc_wake_qual #(.NUM_IRQ(NUM_IRQ)) i_wake (
        .irq_req (irq_req),
        .irq_en  (irq_en),
        .int_mask(int_mask),
        .wake    (wake)
    );

    pmc_settle_cnt #(.SETTLE_W(SETTLE_W)) i_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (settle_load),
        .load_val(settle_cycles),
        .done    (settle_done)
    );

    pmc_rst_strobe #(.NUM_PERIPH(NUM_PERIPH)) i_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (enter_stby),
        .mask  (periph_rst_mask),
        .strobe(periph_rst)
    );

    // Decode helper conditions from the present state.
    always_comb begin
        running     = (state_q == ST_ACTIVE) || (state_q == ST_SUBACT);
        enter_stby  = running && sleep_req && standby_sel;
        settle_load = (state_q == ST_STANDBY) && wake;
        wake_dest   = low_speed_sel ? ST_SUBACT : ST_ACTIVE;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RESET:   state_d = ST_ACTIVE;
            ST_ACTIVE,
            ST_SUBACT:  if (sleep_req) state_d = standby_sel ? ST_STANDBY : ST_SLEEP;
            ST_SLEEP:   if (wake) state_d = wake_dest;
            ST_STANDBY: if (wake) state_d = ST_SETTLE;
            ST_SETTLE:  if (settle_done) state_d = wake_dest;
            default:    state_d = ST_RESET;
        endcase
    end

    // State register; the reset pin wins over every transition.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    // Output decode from the registered state.
    always_comb begin
        cpu_clk_en  = running;
        per_clk_en  = running || (state_q == ST_SLEEP);
        io_hiz      = (state_q == ST_STANDBY) || (state_q == ST_SETTLE);
        per_div_sel = clk_div_sel;
        case (state_q)
            ST_ACTIVE:  mode = MODE_ACTIVE;
            ST_SUBACT:  mode = MODE_SUBACT;
            ST_SLEEP:   mode = MODE_SLEEP;
            ST_STANDBY,
            ST_SETTLE:  mode = MODE_STANDBY;
            default:    mode = MODE_RESET;
        endcase
    end

    // R1: released reset always lands in active.
    p_release_active_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RESET) |=> (mode == MODE_ACTIVE));

    // R3: sleep request without standby select reaches sleep.
    p_sleep_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && sleep_req && !standby_sel) |=> (mode == MODE_SLEEP && !cpu_clk_en && per_clk_en));

    // R5: sleep is held without a qualified wake.
    p_sleep_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SLEEP && !wake) |=> (mode == MODE_SLEEP));

    // R6: wake target follows the low-speed bit.
    p_wake_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SLEEP && wake) |=> (mode == (low_speed_sel_q ? MODE_SUBACT : MODE_ACTIVE)));

    // R7: standby entry stops both clocks and floats the pins.
    p_standby_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        enter_stby |=> (io_hiz && !cpu_clk_en && !per_clk_en));

    // R8: the peripheral reset strobe lasts a single cycle.
    p_strobe_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_rst != '0) |=> (periph_rst == '0));

    // R9: pins stay floating until the settling count expires.
    p_settle_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && !settle_done) |=> (io_hiz && !cpu_clk_en));

    // Registered copy of the low-speed bit for the R6 property.
    logic low_speed_sel_q;
    always_ff @(posedge clk) begin
        if (!rst_n) low_speed_sel_q <= 1'b0;
        else        low_speed_sel_q <= low_speed_sel;
    end

endmodule

// File: tb/test_pmc_power_ctrl.sv
// Bench for pmc_power_ctrl: directed corners then seeded random stimulus,
// checked every cycle against a cycle-level reference model.
module test_pmc_power_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 8;
    localparam int NP = 6;
    localparam int SW = 8;
    localparam int DW = 3;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          rst_n, sleep_req, standby_sel, low_speed_sel, int_mask;
    logic [DW-1:0] clk_div_sel;
    logic [NI-1:0] irq_req, irq_en;
    logic [NP-1:0] periph_rst_mask;
    logic [SW-1:0] settle_cycles;
    logic          cpu_clk_en, per_clk_en, io_hiz;
    logic [DW-1:0] per_div_sel;
    logic [NP-1:0] periph_rst;
    logic [2:0]    mode;

    pmc_power_ctrl #(.NUM_IRQ(NI), .NUM_PERIPH(NP), .SETTLE_W(SW), .DIV_W(DW)) i_pmc_power_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .standby_sel(standby_sel),
        .low_speed_sel(low_speed_sel), .clk_div_sel(clk_div_sel), .irq_req(irq_req),
        .irq_en(irq_en), .int_mask(int_mask), .periph_rst_mask(periph_rst_mask),
        .settle_cycles(settle_cycles), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .per_div_sel(per_div_sel), .io_hiz(io_hiz), .periph_rst(periph_rst), .mode(mode)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Model states: 0 reset, 1 active, 2 subactive, 3 sleep, 4 standby, 5 settling.
    int            m_st = 0;
    int            m_cnt = 0;
    logic [NP-1:0] m_prst = '0;
    string         m_tag = "R1";

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int mode_of(int st);
        return (st == 5) ? 4 : st;
    endfunction

    function automatic bit model_wake();
        return ((irq_req & irq_en) != '0) && !int_mask;
    endfunction

    // Advance the reference model by one edge using the current inputs.
    task automatic model_step();
        int  nst;
        bit  wk;
        wk = model_wake();
        if (!rst_n) begin
            m_tag = (m_st != 0) ? "R10" : "R1";
            m_st = 0; m_cnt = 0; m_prst = '0;
            return;
        end
        nst = m_st;
        m_tag = "R2";
        case (m_st)
            0: begin nst = 1; m_tag = "R1"; end
            1, 2: if (sleep_req) begin
                nst = standby_sel ? 4 : 3;
                m_tag = standby_sel ? "R7" : "R3";
            end
            3: begin
                if (wk) begin nst = low_speed_sel ? 2 : 1; m_tag = "R6"; end
                else m_tag = "R5";
            end
            4: begin
                if (wk) begin nst = 5; m_tag = "R9"; end
                else m_tag = "R5";
            end
            5: begin
                m_tag = "R9";
                if (m_cnt == 0) nst = low_speed_sel ? 2 : 1;
            end
            default: nst = 0;
        endcase
        m_prst = ((m_st == 1 || m_st == 2) && sleep_req && standby_sel) ? periph_rst_mask : '0;
        if (m_st == 4 && wk) m_cnt = int'(settle_cycles);
        else if (m_cnt != 0) m_cnt--;
        m_st = nst;
    endtask

    task automatic check_all();
        chk(m_tag, "mode", int'(mode), mode_of(m_st));
        chk(m_tag, "cpu_clk_en", int'(cpu_clk_en), int'(m_st == 1 || m_st == 2));
        chk(m_tag, "per_clk_en", int'(per_clk_en), int'(m_st == 1 || m_st == 2 || m_st == 3));
        chk(m_tag, "io_hiz", int'(io_hiz), int'(m_st == 4 || m_st == 5));
        chk("R8", "periph_rst", int'(periph_rst), int'(m_prst));
        chk("R4", "per_div_sel", int'(per_div_sel), int'(clk_div_sel));
    endtask

    // One clock: model follows the edge, outputs checked mid-cycle.
    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all();
    endtask

    task automatic idle_inputs();
        sleep_req = 1'b0; standby_sel = 1'b0; low_speed_sel = 1'b0; int_mask = 1'b0;
        irq_req = '0; irq_en = '0; rst_n = 1'b1;
    endtask

    task automatic rand_inputs();
        rst_n         = ($urandom % 100) >= 2;
        sleep_req     = ($urandom % 100) < 20;
        standby_sel   = $urandom % 2;
        low_speed_sel = $urandom % 2;
        int_mask      = ($urandom % 100) < 30;
        clk_div_sel   = DW'($urandom);
        irq_en        = NI'($urandom);
        irq_req       = (($urandom % 100) < 25) ? NI'($urandom) : '0;
        periph_rst_mask = NP'($urandom);
        settle_cycles = SW'($urandom % 8);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        idle_inputs();
        rst_n = 1'b0; clk_div_sel = 3'd5; periph_rst_mask = 6'b101001; settle_cycles = 8'd3;
        @(negedge clk);
        repeat (3) cycle();
        // R1: reset state visible, then active on release.
        chk("R1", "reset mode", int'(mode), 0);
        rst_n = 1'b1;
        cycle();
        chk("R1", "mode after release", int'(mode), 1);

        // R5: masked interrupt leaves sleep untouched.
        sleep_req = 1'b1; cycle(); sleep_req = 1'b0;
        irq_req = 8'h04; irq_en = 8'h04; int_mask = 1'b1;
        repeat (4) cycle();
        chk("R5", "masked sleep hold", int'(mode), 3);
        irq_en = 8'h00; int_mask = 1'b0; cycle();
        chk("R5", "disabled sleep hold", int'(mode), 3);
        irq_en = 8'h04; cycle();
        chk("R6", "wake to active", int'(mode), 1);

        // Sleep request together with a qualified wake: one sleep cycle, then subactive.
        low_speed_sel = 1'b1; sleep_req = 1'b1; cycle();
        chk("R3", "sleep with pending wake", int'(mode), 3);
        sleep_req = 1'b0; cycle();
        chk("R6", "wake to subactive", int'(mode), 2);

        // R7/R8/R9: standby with zero settling count.
        idle_inputs(); settle_cycles = 8'd0;
        sleep_req = 1'b1; standby_sel = 1'b1; cycle();
        chk("R8", "strobe on entry", int'(periph_rst), 6'b101001);
        sleep_req = 1'b0; cycle();
        chk("R8", "strobe cleared", int'(periph_rst), 0);
        irq_req = 8'h80; irq_en = 8'h80; cycle();
        irq_req = '0;
        chk("R9", "settling hiz", int'(io_hiz), 1);
        cycle();
        chk("R9", "zero-settle exit", int'(mode), 1);

        // R10: reset lands during a long settling interval.
        settle_cycles = 8'd5; sleep_req = 1'b1; standby_sel = 1'b1; cycle();
        sleep_req = 1'b0; irq_req = 8'h80; cycle(); irq_req = '0;
        repeat (2) cycle();
        rst_n = 1'b0; irq_req = 8'h80; cycle();
        chk("R10", "reset overrides settle", int'(mode), 0);
        idle_inputs(); cycle();

        // Seeded random phase.
        for (int i = 0; i < 4000; i++) begin
            rand_inputs();
            cycle();
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule